// File: doc/BRIEF.md
# Two-Pin Event Interrupt Router

This block gathers seven event indications from a motion sensor's detection logic and turns them into two interrupt lines. The indications are a new-sample level, a FIFO fill level, and five one-cycle event strobes (single tap, double tap, activity, inactivity and free fall). Each indication keeps a source flag. The strobed events are sticky and hold until software reads the source register. The two data-related flags follow their live condition and are not cleared by that read.

Each flag passes through an enable mask. A map mask then sends it to one of the two lines, and every line is the OR of the flags routed to it. A single polarity bit inverts both lines together. Software uses a small register port to set the enable, map, polarity and watermark level, and to read the source flags. There is no streaming interface, so back-pressure does not apply: a register access completes in the cycle it is presented and never stalls. The interrupt lines are combinational functions of registered state. They change right after the clock edge that updates a flag or a setting.

Top module: `evt_irq_router`

## Requirements
- R1: After reset the flags, enable mask, map mask and polarity bit are zero, the watermark level is 16, both lines are low, and a source read returns 0x00.
- R2: A flag whose map bit is 0 drives `irq_a`, and one whose map bit is 1 drives `irq_b`. Map bit positions match the flag positions: bit0 new-sample, bit1 watermark, bit2 single tap, bit3 double tap, bit4 activity, bit5 inactivity, bit6 free fall.
- R3: A set flag affects a line only while its enable bit (same bit position) is 1. A disabled event is still recorded in the source register.
- R4: Strobe `evt_strobe[k]` sets flag bit k+2. That flag stays set through any number of idle cycles.
- R5: A read of address 4 returns, on `reg_rdata` after that edge, the flags held before the edge. The same edge clears flags 2 to 6, except for a flag whose strobe arrives in that same cycle, which stays set.
- R6: When bit0 of address 2 is 1, both lines are inverted, so they are high when idle and low when asserted.
- R7: A line is high when any enabled flag mapped to it is set. Clearing one of several such flags leaves the line high.
- R8: Clearing an enable bit drops its line right after the write edge, and the flag stays readable at address 4.
- R9: Flag bit0 follows `data_avail` one edge later. A source read does not clear it.
- R10: Flag bit1 sets when `fifo_count` equals the watermark level. It stays set while the count is above the level, clears once the count is below the level, and is not cleared by a source read.
- R11: Registers are read and written by address: 0 enable mask, 1 map mask, 2 polarity (bit0), 3 watermark level, 4 source flags (read only). A read returns its value on `reg_rdata` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_strobe | input | 5 | One-cycle strobes: single tap, double tap, activity, inactivity, free fall |
| data_avail | input | 1 | Level: unread sample data exists |
| fifo_count | input | 6 | Current FIFO sample count |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_a | output | 1 | First interrupt line |
| irq_b | output | 1 | Second interrupt line |

## Verification
A wrongly latched or wrongly cleared flag shows on the routed line right after the edge that corrupts it. It also shows in the source read issued next, one edge later. A bad map or enable bit moves the assertion to the wrong line, or removes it, right after the edge that writes the setting. The same-cycle read-and-strobe case and the watermark equality boundary are driven on purpose, because an off-by-one error there changes only a single flag bit on a single read.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC   = 7;
  localparam int NUM_EVT   = 5;
  localparam int EVT_BASE  = 2;
  localparam int SRC_DRDY  = 0;
  localparam int SRC_WMARK = 1;
  localparam int NUM_PINS  = 2;

  typedef enum logic [2:0] {
    ADR_ENABLE = 3'd0,
    ADR_MAP    = 3'd1,
    ADR_CFG    = 3'd2,
    ADR_WMLVL  = 3'd3,
    ADR_SOURCE = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter int NSRC    = NUM_SRC,
  parameter int FIFO_W  = 6,
  parameter int WM_RST  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   src_flags,
  output logic [NSRC-1:0]   en_mask,
  output logic [NSRC-1:0]   map_mask,
  output logic              invert,
  output logic [FIFO_W-1:0] wm_level,
  output logic              src_rd,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rd_mux;

  assign src_rd = rd_en && (addr == ADDR_W'(ADR_SOURCE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_mask  <= '0;
      map_mask <= '0;
      invert   <= 1'b0;
      wm_level <= FIFO_W'(WM_RST);
    end else if (wr_en) begin
      case (addr)
        ADDR_W'(ADR_ENABLE): en_mask  <= wdata[NSRC-1:0];
        ADDR_W'(ADR_MAP):    map_mask <= wdata[NSRC-1:0];
        ADDR_W'(ADR_CFG):    invert   <= wdata[0];
        ADDR_W'(ADR_WMLVL):  wm_level <= wdata[FIFO_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(ADR_ENABLE): rd_mux = DATA_W'(en_mask);
      ADDR_W'(ADR_MAP):    rd_mux = DATA_W'(map_mask);
      ADDR_W'(ADR_CFG):    rd_mux = DATA_W'(invert);
      ADDR_W'(ADR_WMLVL):  rd_mux = DATA_W'(wm_level);
      ADDR_W'(ADR_SOURCE): rd_mux = DATA_W'(src_flags);
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
#(
  parameter int NSRC   = NUM_SRC,
  parameter int NEVT   = NUM_EVT,
  parameter int FIFO_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEVT-1:0]   evt_strobe,
  input  logic              data_avail,
  input  logic [FIFO_W-1:0] fifo_count,
  input  logic [FIFO_W-1:0] wm_level,
  input  logic              src_rd,
  output logic [NSRC-1:0]   flags
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == SRC_DRDY) begin : g_level
      always_ff @(posedge clk) begin
        if (!rst_n) flags[i] <= 1'b0;
        else        flags[i] <= data_avail;
      end
    end else if (i == SRC_WMARK) begin : g_wmark
      always_ff @(posedge clk) begin
        if (!rst_n)                       flags[i] <= 1'b0;
        else if (fifo_count < wm_level)   flags[i] <= 1'b0;
        else if (fifo_count == wm_level)  flags[i] <= 1'b1;
      end
    end else begin : g_sticky
      always_ff @(posedge clk) begin
        if (!rst_n) flags[i] <= 1'b0;
        else        flags[i] <= (flags[i] & ~src_rd) | evt_strobe[i-EVT_BASE];
      end
    end
  end
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
  import irq_pkg::*;
#(
  parameter int NSRC  = NUM_SRC,
  parameter int NPINS = NUM_PINS
) (
  input  logic [NSRC-1:0]  flags,
  input  logic [NSRC-1:0]  en_mask,
  input  logic [NSRC-1:0]  map_mask,
  input  logic             invert,
  output logic [NPINS-1:0] pins
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [NSRC-1:0] routed;
    always_comb begin
      for (int s = 0; s < NSRC; s++)
        routed[s] = flags[s] & en_mask[s] & (map_mask[s] == p[0]);
      pins[p] = invert ^ (|routed);
    end
  end
endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router
  import irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int FIFO_W = 6,
  parameter int WM_RST = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EVT-1:0]  evt_strobe,
  input  logic                data_avail,
  input  logic [FIFO_W-1:0]   fifo_count,
  input  logic                reg_wr_en,
  input  logic                reg_rd_en,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq_a,
  output logic                irq_b
);
  logic [NUM_SRC-1:0]  flags;
  logic [NUM_SRC-1:0]  en_mask;
  logic [NUM_SRC-1:0]  map_mask;
  logic                invert;
  logic [FIFO_W-1:0]   wm_level;
  logic                src_rd;
  logic [NUM_PINS-1:0] pins;

  irq_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NSRC(NUM_SRC),
    .FIFO_W(FIFO_W), .WM_RST(WM_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .src_flags(flags),
    .en_mask(en_mask), .map_mask(map_mask), .invert(invert),
    .wm_level(wm_level), .src_rd(src_rd), .rdata(reg_rdata)
  );

  irq_flag_bank #(
    .NSRC(NUM_SRC), .NEVT(NUM_EVT), .FIFO_W(FIFO_W)
  ) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe),
    .data_avail(data_avail), .fifo_count(fifo_count),
    .wm_level(wm_level), .src_rd(src_rd), .flags(flags)
  );

  irq_pin_router #(
    .NSRC(NUM_SRC), .NPINS(NUM_PINS)
  ) u_route (
    .flags(flags), .en_mask(en_mask), .map_mask(map_mask),
    .invert(invert), .pins(pins)
  );

  assign irq_a = pins[0];
  assign irq_b = pins[1];
endmodule

// File: rtl/evt_irq_router_chk.sv
module evt_irq_router_chk
  import irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FIFO_W = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_EVT-1:0]  evt_strobe,
  input logic                data_avail,
  input logic [FIFO_W-1:0]   fifo_count,
  input logic [FIFO_W-1:0]   wm_level,
  input logic                src_rd,
  input logic [NUM_SRC-1:0]  flags,
  input logic [NUM_SRC-1:0]  en_mask,
  input logic                invert,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic                irq_a,
  input logic                irq_b
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_STROBE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_strobe[0] |=> flags[EVT_BASE]);  // R4

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && flags[EVT_BASE+1] && !src_rd) |=> flags[EVT_BASE+1]);  // R4

  AST_READ_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && src_rd) |=> reg_rdata == DATA_W'($past(flags)));  // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd && !evt_strobe[4]) |=> !flags[EVT_BASE+4]);  // R5

  AST_DRDY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> flags[SRC_DRDY] == $past(data_avail));  // R9

  AST_WM_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == wm_level) |=> flags[SRC_WMARK]);  // R10

  AST_WM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count < wm_level) |=> !flags[SRC_WMARK]);  // R10

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & en_mask) == '0) |-> (irq_a == invert && irq_b == invert));  // R6

  AST_ONE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(flags & en_mask) == 1) |-> (irq_a != irq_b));  // R2
endmodule

bind evt_irq_router evt_irq_router_chk #(.DATA_W(DATA_W), .FIFO_W(FIFO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .data_avail(data_avail),
  .fifo_count(fifo_count), .wm_level(wm_level), .src_rd(src_rd),
  .flags(flags), .en_mask(en_mask), .invert(invert),
  .reg_rdata(reg_rdata), .irq_a(irq_a), .irq_b(irq_b)
);

// File: tb/evt_irq_router_test.sv
module evt_irq_router_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] evt_strobe = '0;
  logic       data_avail = 1'b0;
  logic [5:0] fifo_count = '0;
  logic       reg_wr_en = 1'b0;
  logic       reg_rd_en = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_a, irq_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    string    tag;
    logic     a;
    logic     b;
    logic [7:0] rd;
    bit       use_rd;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  evt_irq_router uut (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .data_avail(data_avail),
    .fifo_count(fifo_count), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_pins(string tag, logic a, logic b);
    item_t it;
    it.tag = tag; it.a = a; it.b = b; it.rd = '0; it.use_rd = 1'b0;
    sb.push_back(it);
  endtask

  task automatic expect_read(string tag, logic a, logic b, logic [7:0] rd);
    item_t it;
    it.tag = tag; it.a = a; it.b = b; it.rd = rd; it.use_rd = 1'b1;
    sb.push_back(it);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a);
    reg_rd_en = 1'b1; reg_addr = a;
    step();
    reg_rd_en = 1'b0;
  endtask

  task automatic pulse(int k);
    evt_strobe[k] = 1'b1;
    step();
    evt_strobe = '0;
  endtask

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_cmp++;
        if (irq_a !== it.a || irq_b !== it.b) begin
          n_bad++;
          $display("FAIL %s: pins a/b = %b/%b, expected %b/%b", it.tag, irq_a, irq_b, it.a, it.b);
        end
        if (it.use_rd) begin
          n_cmp++;
          if (reg_rdata !== it.rd) begin
            n_bad++;
            $display("FAIL %s: rdata = 0x%02h, expected 0x%02h", it.tag, reg_rdata, it.rd);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    expect_pins("R1 reset lines low", 1'b0, 1'b0);
    rd(3'd4); expect_read("R1 source empty", 1'b0, 1'b0, 8'h00);
    rd(3'd3); expect_read("R1 watermark default", 1'b0, 1'b0, 8'h10);

    wr(3'd0, 8'h7F);
    wr(3'd1, 8'h00);
    pulse(0); expect_pins("R3 enabled single tap on A", 1'b1, 1'b0);
    repeat (3) step();
    expect_pins("R4 flag held", 1'b1, 1'b0);
    rd(3'd4); expect_read("R5 read snapshot and clear", 1'b0, 1'b0, 8'h04);

    wr(3'd1, 8'h08);
    pulse(1); expect_pins("R2 double tap routed to B", 1'b0, 1'b1);
    rd(3'd4); expect_read("R2 source shows bit3", 1'b0, 1'b0, 8'h08);

    evt_strobe[2] = 1'b1; reg_rd_en = 1'b1; reg_addr = 3'd4;
    step();
    evt_strobe = '0; reg_rd_en = 1'b0;
    expect_read("R5 same-cycle strobe survives", 1'b1, 1'b0, 8'h00);
    rd(3'd4); expect_read("R5 survivor read", 1'b0, 1'b0, 8'h10);

    wr(3'd0, 8'h5F);
    pulse(3); expect_pins("R3 disabled inactivity silent", 1'b0, 1'b0);
    rd(3'd4); expect_read("R3 disabled still recorded", 1'b0, 1'b0, 8'h20);

    pulse(4); expect_pins("R8 free fall asserts A", 1'b1, 1'b0);
    wr(3'd0, 8'h1F); expect_pins("R8 enable cleared drops line", 1'b0, 1'b0);
    rd(3'd4); expect_read("R8 flag kept", 1'b0, 1'b0, 8'h40);

    wr(3'd0, 8'h7F);
    wr(3'd2, 8'h01); expect_pins("R6 inverted idle high", 1'b1, 1'b1);
    pulse(0); expect_pins("R6 inverted asserted low", 1'b0, 1'b1);
    rd(3'd4); expect_read("R6 clear returns idle", 1'b1, 1'b1, 8'h04);
    wr(3'd2, 8'h00); expect_pins("R6 back to normal", 1'b0, 1'b0);

    data_avail = 1'b1; step(); expect_pins("R9 sample ready on A", 1'b1, 1'b0);
    rd(3'd4); expect_read("R9 read does not clear", 1'b1, 1'b0, 8'h01);
    step(); expect_pins("R9 still set", 1'b1, 1'b0);
    data_avail = 1'b0; step(); expect_pins("R9 follows level low", 1'b0, 1'b0);

    data_avail = 1'b1; step();
    pulse(0); expect_pins("R7 two sources on A", 1'b1, 1'b0);
    rd(3'd4); expect_read("R7 one cleared line stays", 1'b1, 1'b0, 8'h05);
    data_avail = 1'b0; step(); expect_pins("R7 all cleared", 1'b0, 1'b0);

    wr(3'd3, 8'h04);
    wr(3'd1, 8'h0A);
    fifo_count = 6'd3; step(); expect_pins("R10 below level", 1'b0, 1'b0);
    fifo_count = 6'd4; step(); expect_pins("R10 equal sets on B", 1'b0, 1'b1);
    fifo_count = 6'd5; step(); expect_pins("R10 above holds", 1'b0, 1'b1);
    rd(3'd4); expect_read("R10 read does not clear", 1'b0, 1'b1, 8'h02);
    fifo_count = 6'd3; step(); expect_pins("R10 below clears", 1'b0, 1'b0);
    fifo_count = 6'd0;

    rd(3'd0); expect_read("R11 enable readback", 1'b0, 1'b0, 8'h7F);
    rd(3'd1); expect_read("R11 map readback", 1'b0, 1'b0, 8'h0A);
    rd(3'd3); expect_read("R11 level readback", 1'b0, 1'b0, 8'h04);
    rd(3'd2); expect_read("R11 polarity readback", 1'b0, 1'b0, 8'h00);

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule